// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wake-Up Qualification

This block sits in the always-on domain of a small dual-core system and moves it between three power modes: Active, Wait and Backup. Software asks for Wait with a single request pulse. Backup is requested either by a regulator-off request pulse or by a wait-for-event request while the deep-sleep select is high. Both sleep modes pass through a short entry phase before any clock or supply control changes, and a qualified wake-up during that phase cancels the entry.

In Wait, the block turns off the bus, peripheral and per-core clock enables and puts the core regulator into standby. All logic stays powered, so execution resumes with its state intact after a bounded start-up phase. In Backup, the block first turns the core regulator off and then pulls the shutdown output low. Leaving Backup always passes through a system reset pulse. Only the wake-enable and wake-status registers held inside this block survive that reset.

Each wake source has its own enable bit. A one-hot sticky status register records which enabled sources ended a sleep or an entry attempt. Software clears status bits by writing 1 to them.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_ni` is released, the outputs hold these values:
  - `mode_o` is 0 (Active).
  - All clock enables, `reg_on_o`, `shdn_o` and `sys_rst_no` are 1.
  - `reg_stby_o`, `wait_err_o`, `wake_en_o` and `wake_stat_o` are 0.
- R2: `wait_req_i` in Active starts the Wait entry, provided `mck_is_frc_i` and `ss1_stopped_i` are both 1.
  - For ENTRY_CYC cycles the clocks keep running and `mode_o` stays 0.
  - The block then enters Wait: `mode_o`=1, the bus and core clock enables are 0, and `reg_stby_o`=1.
- R3: A Wait request that lacks either precondition leaves the block in Active and sets `wait_err_o`.
  - The flag stays set until an `err_clr_i` pulse clears it.
  - A new set in the same cycle as a clear wins.
- R4: Backup is requested by `regoff_req_i`, or by `wfe_req_i` while `deep_sleep_i`=1.
  - `wfe_req_i` with `deep_sleep_i`=0 is ignored.
  - When Backup and Wait are requested together, Backup is taken.
  - After ENTRY_CYC entry cycles, `reg_on_o` goes 0 while `shdn_o` stays 1 for REGOFF_CYC cycles (`mode_o`=2).
  - `shdn_o` then goes 0.
- R5: `shdn_o` is 0 only when `reg_on_o` was already 0 in the previous cycle. Supply-monitor events never pull `shdn_o` low.
- R6: Wake source bit positions are as follows, where P = NUM_PINS:
  - Pins occupy bits [P-1:0].
  - Force pin is bit P.
  - Supply-fall is bit P+1.
  - Tamper is bit P+2.
  - RTC alarm is bit P+3.
  - RTT alarm is bit P+4.
  - A source counts only while its bit in `wake_en_o` is 1. The enable register loads `wake_en_wdata_i` when `wake_en_we_i` is 1.
- R7: In Wait, only enabled pins, tamper, RTC and RTT wake the block; force and supply-fall are ignored.
  - On a wake, `reg_stby_o` drops on the next cycle.
  - The clocks stay gated for WAKE_CYC cycles and the block then returns to Active.
  - WAKE_CYC must not exceed WAKE_BUDGET_CYC.
- R8: In Backup, or in the regulator-off phase before it, any enabled source starts a reset phase.
  - The reset phase lasts RST_CYC cycles with `reg_on_o`=1, `shdn_o`=1, clocks enabled and `sys_rst_no`=0.
  - The block then returns to Active.
- R9: The Backup-exit reset clears `wait_err_o`. It keeps `wake_en_o` and `wake_stat_o` unchanged.
- R10: An enabled wake of the right class during either entry phase returns the block to Active on the next cycle, and the clock enables never drop.
- R11: Every wake taken ORs the qualifying enabled sources into `wake_stat_o`; this includes an entry that is cancelled.
  - A 1 on a bit of `wake_stat_clr_i` clears that status bit.
  - A set wins over a clear in the same cycle.
- R12: Entry requests are ignored in every state other than Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wait_req_i | input | 1 | Wait entry request pulse |
| regoff_req_i | input | 1 | Regulator-off (Backup) request pulse |
| wfe_req_i | input | 1 | Wait-for-event request pulse |
| deep_sleep_i | input | 1 | Deep-sleep select for wait-for-event |
| mck_is_frc_i | input | 1 | Main clock runs from the internal fast RC |
| ss1_stopped_i | input | 1 | Sub-system 1 reports stopped |
| err_clr_i | input | 1 | Clears the Wait request error flag |
| wkup_pin_i | input | NUM_PINS | Wake-up pins |
| force_wkup_i | input | 1 | Force wake-up pin |
| supply_fall_i | input | 1 | Falling-supply monitor event |
| tamper_i | input | 1 | Tamper detection event |
| rtc_alarm_i | input | 1 | RTC alarm |
| rtt_alarm_i | input | 1 | RTT alarm |
| wake_en_we_i | input | 1 | Write strobe for the wake-enable register |
| wake_en_wdata_i | input | NUM_PINS+5 | New wake-enable value |
| wake_stat_clr_i | input | NUM_PINS+5 | Write-1-to-clear mask for wake status |
| mode_o | output | 2 | 0 Active, 1 Wait, 2 Backup |
| bus_clk_en_o | output | 1 | Bus and peripheral clock enable |
| core_clk_en_o | output | NUM_CORES | Per-core clock enables |
| reg_on_o | output | 1 | Core regulator enable |
| reg_stby_o | output | 1 | Core regulator standby |
| shdn_o | output | 1 | Shutdown output, low in Backup |
| sys_rst_no | output | 1 | System reset, active low |
| wait_err_o | output | 1 | Sticky rejected-Wait flag |
| wake_en_o | output | NUM_PINS+5 | Wake-enable register |
| wake_stat_o | output | NUM_PINS+5 | Sticky wake-source status |

## Verification
The bench builds the block with NUM_PINS=6, ENTRY_CYC=2, REGOFF_CYC=3, WAKE_CYC=4, RST_CYC=3 and WAKE_BUDGET_CYC=8. With these short timers, every phase boundary falls within a few cycles of its trigger. The test can therefore check the exact cycle on which clocks re-enable, the regulator drops and the shutdown output falls, in every phase. With six pins, enabled and disabled pins can be exercised side by side. Both excluded Wait sources and both Backup-only sources sit at fixed indices that the model computes from NUM_PINS.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE  = 3'd0,
    PM_W_ENTRY = 3'd1,
    PM_WAIT    = 3'd2,
    PM_W_WAKE  = 3'd3,
    PM_B_ENTRY = 3'd4,
    PM_B_OFF   = 3'd5,
    PM_BACKUP  = 3'd6,
    PM_B_RST   = 3'd7
  } pm_state_e;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_WAIT   = 2'd1,
    MODE_BACKUP = 2'd2
  } pm_mode_e;

  function automatic int unsigned pm_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwr_wake_mask.sv
module pwr_wake_mask #(
  parameter int unsigned NUM_PINS = 14
) (
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                force_i,
  input  logic                supply_fall_i,
  input  logic                tamper_i,
  input  logic                rtc_i,
  input  logic                rtt_i,
  input  logic [NUM_PINS+4:0] en_i,
  output logic [NUM_PINS+4:0] hit_all_o,
  output logic [NUM_PINS+4:0] hit_wait_o,
  output logic                any_all_o,
  output logic                any_wait_o
);
  localparam int unsigned SRC_W = NUM_PINS + 5;

  logic [SRC_W-1:0] src;
  logic [SRC_W-1:0] wait_mask;

  assign src = {rtt_i, rtc_i, tamper_i, supply_fall_i, force_i, pin_i};

  // force pin and supply monitor are backup-only sources
  for (genvar i = 0; i < SRC_W; i++) begin : g_wmask
    if ((i == NUM_PINS) || (i == NUM_PINS + 1)) begin : g_bk_only
      assign wait_mask[i] = 1'b0;
    end else begin : g_both
      assign wait_mask[i] = 1'b1;
    end
  end

  assign hit_all_o  = src & en_i;
  assign hit_wait_o = hit_all_o & wait_mask;
  assign any_all_o  = |hit_all_o;
  assign any_wait_o = |hit_wait_o;

endmodule

// File: rtl/pwr_bkp_regs.sv
module pwr_bkp_regs #(
  parameter int unsigned SRC_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic [SRC_W-1:0] en_wdata_i,
  input  logic [SRC_W-1:0] clr_i,
  input  logic [SRC_W-1:0] set_i,
  output logic [SRC_W-1:0] en_o,
  output logic [SRC_W-1:0] stat_o
);
  logic [SRC_W-1:0] en_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      stat_q <= (stat_q & ~clr_i) | set_i;
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;

  a_r6_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q))
    else $error("wake enable changed without write");

  a_r11_stat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stat_q) |=> ((($past(stat_q) & ~stat_q) & ~$past(clr_i)) == '0))
    else $error("wake status bit dropped without clear");

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)))
    else $error("wake status set lost");

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_CORES       = 2,
  parameter int unsigned ENTRY_CYC       = 4,
  parameter int unsigned REGOFF_CYC      = 8,
  parameter int unsigned WAKE_CYC        = 40,
  parameter int unsigned RST_CYC         = 16,
  parameter int unsigned WAKE_BUDGET_CYC = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wait_req_i,
  input  logic                 regoff_req_i,
  input  logic                 wfe_req_i,
  input  logic                 deep_sleep_i,
  input  logic                 mck_is_frc_i,
  input  logic                 ss1_stopped_i,
  input  logic                 err_clr_i,
  input  logic                 any_all_i,
  input  logic                 any_wait_i,
  output logic                 take_wait_o,
  output logic                 take_bkp_o,
  output logic [1:0]           mode_o,
  output logic                 bus_clk_en_o,
  output logic [NUM_CORES-1:0] core_clk_en_o,
  output logic                 reg_on_o,
  output logic                 reg_stby_o,
  output logic                 shdn_o,
  output logic                 sys_rst_no,
  output logic                 wait_err_o
);
  localparam int unsigned MAX_C = pm_max(pm_max(ENTRY_CYC, REGOFF_CYC), pm_max(WAKE_CYC, RST_CYC));
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);
  localparam int unsigned WB_W  = $clog2(WAKE_BUDGET_CYC + 2);

  if ((ENTRY_CYC == 0) || (REGOFF_CYC == 0) || (WAKE_CYC == 0) || (RST_CYC == 0) ||
      (WAKE_CYC > WAKE_BUDGET_CYC)) begin : g_bad_cfg
    $error("pwr_seq_fsm: phase lengths must be nonzero and wake within budget");
  end

  pm_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  int unsigned      limit;
  logic             done, timed, bkp_req, wait_ok, err_set, clk_on;

  assign bkp_req = regoff_req_i | (wfe_req_i & deep_sleep_i);
  assign wait_ok = mck_is_frc_i & ss1_stopped_i;
  assign err_set = (st_q == PM_ACTIVE) && !bkp_req && wait_req_i && !wait_ok;

  always_comb begin
    unique case (st_q)
      PM_W_ENTRY, PM_B_ENTRY: limit = ENTRY_CYC;
      PM_W_WAKE:              limit = WAKE_CYC;
      PM_B_OFF:               limit = REGOFF_CYC;
      PM_B_RST:               limit = RST_CYC;
      default:                limit = 1;
    endcase
  end

  assign timed = (st_q == PM_W_ENTRY) || (st_q == PM_B_ENTRY) || (st_q == PM_W_WAKE) ||
                 (st_q == PM_B_OFF) || (st_q == PM_B_RST);
  assign done  = ({{(32-CNT_W){1'b0}}, cnt_q} == (limit - 1));

  assign take_wait_o = ((st_q == PM_W_ENTRY) || (st_q == PM_WAIT)) && any_wait_i;
  assign take_bkp_o  = ((st_q == PM_B_ENTRY) || (st_q == PM_B_OFF) || (st_q == PM_BACKUP)) &&
                       any_all_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_ACTIVE: begin
        if (bkp_req)                  st_d = PM_B_ENTRY;
        else if (wait_req_i && wait_ok) st_d = PM_W_ENTRY;
      end
      PM_W_ENTRY: begin
        if (any_wait_i) st_d = PM_ACTIVE;
        else if (done)  st_d = PM_WAIT;
      end
      PM_WAIT:   if (any_wait_i) st_d = PM_W_WAKE;
      PM_W_WAKE: if (done) st_d = PM_ACTIVE;
      PM_B_ENTRY: begin
        if (any_all_i) st_d = PM_ACTIVE;
        else if (done) st_d = PM_B_OFF;
      end
      PM_B_OFF: begin
        if (any_all_i) st_d = PM_B_RST;
        else if (done) st_d = PM_BACKUP;
      end
      PM_BACKUP: if (any_all_i) st_d = PM_B_RST;
      PM_B_RST:  if (done) st_d = PM_ACTIVE;
      default:   st_d = PM_ACTIVE;
    endcase
  end

  always_comb begin
    if (st_d != st_q)  cnt_d = '0;
    else if (timed)    cnt_d = cnt_q + 1'b1;
    else               cnt_d = '0;
  end

  // backup-exit reset clears the non-retained flag
  always_comb begin
    if (st_q == PM_B_RST) err_d = 1'b0;
    else if (err_set)     err_d = 1'b1;
    else if (err_clr_i)   err_d = 1'b0;
    else                  err_d = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PM_ACTIVE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign clk_on = !((st_q == PM_WAIT) || (st_q == PM_W_WAKE) ||
                    (st_q == PM_B_OFF) || (st_q == PM_BACKUP));

  always_comb begin
    unique case (st_q)
      PM_WAIT, PM_W_WAKE:  mode_o = MODE_WAIT;
      PM_B_OFF, PM_BACKUP: mode_o = MODE_BACKUP;
      default:             mode_o = MODE_ACTIVE;
    endcase
  end

  assign bus_clk_en_o  = clk_on;
  assign core_clk_en_o = {NUM_CORES{clk_on}};
  assign reg_on_o      = !((st_q == PM_B_OFF) || (st_q == PM_BACKUP));
  assign reg_stby_o    = (st_q == PM_WAIT);
  assign shdn_o        = (st_q != PM_BACKUP);
  assign sys_rst_no    = (st_q != PM_B_RST);
  assign wait_err_o    = err_q;

  // checker: cycles spent restarting from Wait
  logic [WB_W-1:0] wk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                            wk_q <= '0;
    else if (!bus_clk_en_o && reg_on_o && !reg_stby_o) begin
      if (wk_q != {WB_W{1'b1}})                             wk_q <= wk_q + 1'b1;
    end else                                                wk_q <= '0;
  end

  a_r7_wake_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{(32-WB_W){1'b0}}, wk_q} <= WAKE_BUDGET_CYC)
    else $error("wait start-up exceeded budget");

  a_r5_shdn_after_regoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shdn_o) |-> $past(!reg_on_o))
    else $error("shutdown before regulator off");

  a_r5_shdn_reg_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_o |-> !reg_on_o)
    else $error("shutdown with regulator on");

  a_r3_err_on_bad_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set |=> (wait_err_o && st_q == PM_ACTIVE))
    else $error("rejected wait not flagged");

  a_r10_abort_keeps_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((st_q == PM_W_ENTRY) && any_wait_i) || ((st_q == PM_B_ENTRY) && any_all_i))
      |=> (st_q == PM_ACTIVE && bus_clk_en_o))
    else $error("entry abort failed");

  a_r12_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PM_WAIT && !any_wait_i) |=> (st_q == PM_WAIT))
    else $error("wait left without wake");

  a_r8_rst_supplies_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> (reg_on_o && shdn_o && bus_clk_en_o))
    else $error("reset phase with supply off");

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int unsigned NUM_PINS        = 14,
  parameter int unsigned NUM_CORES       = 2,
  parameter int unsigned ENTRY_CYC       = 4,
  parameter int unsigned REGOFF_CYC      = 8,
  parameter int unsigned WAKE_CYC        = 40,
  parameter int unsigned RST_CYC         = 16,
  parameter int unsigned WAKE_BUDGET_CYC = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wait_req_i,
  input  logic                 regoff_req_i,
  input  logic                 wfe_req_i,
  input  logic                 deep_sleep_i,
  input  logic                 mck_is_frc_i,
  input  logic                 ss1_stopped_i,
  input  logic                 err_clr_i,
  input  logic [NUM_PINS-1:0]  wkup_pin_i,
  input  logic                 force_wkup_i,
  input  logic                 supply_fall_i,
  input  logic                 tamper_i,
  input  logic                 rtc_alarm_i,
  input  logic                 rtt_alarm_i,
  input  logic                 wake_en_we_i,
  input  logic [NUM_PINS+4:0]  wake_en_wdata_i,
  input  logic [NUM_PINS+4:0]  wake_stat_clr_i,
  output logic [1:0]           mode_o,
  output logic                 bus_clk_en_o,
  output logic [NUM_CORES-1:0] core_clk_en_o,
  output logic                 reg_on_o,
  output logic                 reg_stby_o,
  output logic                 shdn_o,
  output logic                 sys_rst_no,
  output logic                 wait_err_o,
  output logic [NUM_PINS+4:0]  wake_en_o,
  output logic [NUM_PINS+4:0]  wake_stat_o
);
  localparam int unsigned SRC_W = NUM_PINS + 5;

  logic [SRC_W-1:0] hit_all, hit_wait, stat_set;
  logic             any_all, any_wait, take_wait, take_bkp;

  pwr_wake_mask #(.NUM_PINS(NUM_PINS)) u_mask (
    .pin_i        (wkup_pin_i),
    .force_i      (force_wkup_i),
    .supply_fall_i(supply_fall_i),
    .tamper_i     (tamper_i),
    .rtc_i        (rtc_alarm_i),
    .rtt_i        (rtt_alarm_i),
    .en_i         (wake_en_o),
    .hit_all_o    (hit_all),
    .hit_wait_o   (hit_wait),
    .any_all_o    (any_all),
    .any_wait_o   (any_wait)
  );

  pwr_seq_fsm #(
    .NUM_CORES      (NUM_CORES),
    .ENTRY_CYC      (ENTRY_CYC),
    .REGOFF_CYC     (REGOFF_CYC),
    .WAKE_CYC       (WAKE_CYC),
    .RST_CYC        (RST_CYC),
    .WAKE_BUDGET_CYC(WAKE_BUDGET_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wait_req_i   (wait_req_i),
    .regoff_req_i (regoff_req_i),
    .wfe_req_i    (wfe_req_i),
    .deep_sleep_i (deep_sleep_i),
    .mck_is_frc_i (mck_is_frc_i),
    .ss1_stopped_i(ss1_stopped_i),
    .err_clr_i    (err_clr_i),
    .any_all_i    (any_all),
    .any_wait_i   (any_wait),
    .take_wait_o  (take_wait),
    .take_bkp_o   (take_bkp),
    .mode_o       (mode_o),
    .bus_clk_en_o (bus_clk_en_o),
    .core_clk_en_o(core_clk_en_o),
    .reg_on_o     (reg_on_o),
    .reg_stby_o   (reg_stby_o),
    .shdn_o       (shdn_o),
    .sys_rst_no   (sys_rst_no),
    .wait_err_o   (wait_err_o)
  );

  always_comb begin
    if (take_wait)     stat_set = hit_wait;
    else if (take_bkp) stat_set = hit_all;
    else               stat_set = '0;
  end

  pwr_bkp_regs #(.SRC_W(SRC_W)) u_bkp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_we_i   (wake_en_we_i),
    .en_wdata_i(wake_en_wdata_i),
    .clr_i     (wake_stat_clr_i),
    .set_i     (stat_set),
    .en_o      (wake_en_o),
    .stat_o    (wake_stat_o)
  );

  a_r7_wait_sources: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_wait |=> ((wake_stat_o & $past(hit_all) & ~$past(hit_wait)) == ($past(wake_stat_o) & $past(hit_all) & ~$past(hit_wait) & ~$past(wake_stat_clr_i))))
    else $error("backup-only source recorded on wait wake");

  a_r9_en_kept_in_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && !wake_en_we_i) |=> $stable(wake_en_o))
    else $error("wake enables lost in backup reset");

endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int P = 6;
  localparam int W = P + 5;
  localparam int NC = 2;
  localparam int ENT = 2, ROFF = 3, WK = 4, RST = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wait_req = 0, regoff_req = 0, wfe_req = 0, deep = 0, frc = 0, ss1 = 0, err_clr = 0;
  logic [P-1:0] pins = '0;
  logic force_w = 0, supply = 0, tamper = 0, rtc = 0, rtt = 0, en_we = 0;
  logic [W-1:0] en_wdata = '0, stat_clr = '0;
  logic [1:0] mode;
  logic bus_en, reg_on, reg_stby, shdn, srst_n, werr;
  logic [NC-1:0] core_en;
  logic [W-1:0] wake_en, wake_stat;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.NUM_PINS(P), .NUM_CORES(NC), .ENTRY_CYC(ENT), .REGOFF_CYC(ROFF),
                  .WAKE_CYC(WK), .RST_CYC(RST), .WAKE_BUDGET_CYC(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wait_req_i(wait_req), .regoff_req_i(regoff_req),
    .wfe_req_i(wfe_req), .deep_sleep_i(deep), .mck_is_frc_i(frc), .ss1_stopped_i(ss1),
    .err_clr_i(err_clr), .wkup_pin_i(pins), .force_wkup_i(force_w), .supply_fall_i(supply),
    .tamper_i(tamper), .rtc_alarm_i(rtc), .rtt_alarm_i(rtt), .wake_en_we_i(en_we),
    .wake_en_wdata_i(en_wdata), .wake_stat_clr_i(stat_clr), .mode_o(mode),
    .bus_clk_en_o(bus_en), .core_clk_en_o(core_en), .reg_on_o(reg_on), .reg_stby_o(reg_stby),
    .shdn_o(shdn), .sys_rst_no(srst_n), .wait_err_o(werr), .wake_en_o(wake_en),
    .wake_stat_o(wake_stat));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done_flag = 0;
  string cur_tag = "R1";

  // reference model: 0 act,1 wait-entry,2 wait,3 wait-wake,4 bkp-entry,5 reg-off,6 backup,7 bkp-reset
  int m_st = 0, m_cnt = 0;
  bit m_err = 0;
  bit [W-1:0] m_en = '0, m_stat = '0;

  function automatic int lim(int s);
    case (s)
      1, 4: return ENT;
      3: return WK;
      5: return ROFF;
      7: return RST;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_err = 0; m_en = '0; m_stat = '0;
    end else begin
      bit [W-1:0] src, hits, whits;
      bit bk, ok, dn;
      int nst;
      bit [W-1:0] set;
      src = {rtt, rtc, tamper, supply, force_w, pins};
      hits = src & m_en;
      whits = hits;
      whits[P] = 0; whits[P+1] = 0;
      bk = regoff_req | (wfe_req & deep);
      ok = frc & ss1;
      dn = (m_cnt == lim(m_st) - 1);
      nst = m_st; set = '0;
      case (m_st)
        0: if (bk) nst = 4; else if (wait_req && ok) nst = 1;
        1: if (whits != 0) begin nst = 0; set = whits; end else if (dn) nst = 2;
        2: if (whits != 0) begin nst = 3; set = whits; end
        3: if (dn) nst = 0;
        4: if (hits != 0) begin nst = 0; set = hits; end else if (dn) nst = 5;
        5: if (hits != 0) begin nst = 7; set = hits; end else if (dn) nst = 6;
        6: if (hits != 0) begin nst = 7; set = hits; end
        7: if (dn) nst = 0;
        default: nst = 0;
      endcase
      if (m_st == 7) m_err = 0;
      else if (m_st == 0 && !bk && wait_req && !ok) m_err = 1;
      else if (err_clr) m_err = 0;
      m_stat = (m_stat & ~stat_clr) | set;
      if (en_we) m_en = en_wdata;
      m_cnt = (nst != m_st) ? 0 : ((m_st inside {1,3,4,5,7}) ? m_cnt + 1 : 0);
      m_st = nst;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit clk_on;
    int em;
    @(negedge clk);
    clk_on = !(m_st inside {2,3,5,6});
    em = (m_st inside {2,3}) ? 1 : (m_st inside {5,6}) ? 2 : 0;
    check(cur_tag, "mode", 32'(mode), 32'(em));
    check(cur_tag, "bus_clk_en", 32'(bus_en), 32'(clk_on));
    check(cur_tag, "core_clk_en", 32'(core_en), clk_on ? 32'(2'b11) : 32'd0);
    check(cur_tag, "reg_on", 32'(reg_on), 32'(!(m_st inside {5,6})));
    check(cur_tag, "reg_stby", 32'(reg_stby), 32'(m_st == 2));
    check(cur_tag, "shdn", 32'(shdn), 32'(m_st != 6));
    check(cur_tag, "sys_rst_n", 32'(srst_n), 32'(m_st != 7));
    check(cur_tag, "wait_err", 32'(werr), 32'(m_err));
    check(cur_tag, "wake_en", 32'(wake_en), 32'(m_en));
    check(cur_tag, "wake_stat", 32'(wake_stat), 32'(m_stat));
    wait_req = 0; regoff_req = 0; wfe_req = 0; err_clr = 0; pins = '0; force_w = 0;
    supply = 0; tamper = 0; rtc = 0; rtt = 0; en_we = 0; stat_clr = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // bit indices: pins 0..5, force 6, supply 7, tamper 8, rtc 9, rtt 10
  localparam logic [W-1:0] EN_VAL = 11'h345; // pins 0,2, force, tamper, rtc

  initial begin
    cur_tag = "R1";
    ticks(3);
    rst_ni = 1'b1;
    ticks(2);
    check("R1", "reset shdn", 32'(shdn), 32'd1);
    check("R1", "reset mode", 32'(mode), 32'd0);
    check("R1", "reset stat", 32'(wake_stat), 32'd0);

    cur_tag = "R6";
    en_we = 1; en_wdata = EN_VAL; tick(); tick();
    check("R6", "wake_en readback", 32'(wake_en), 32'(EN_VAL));
    pins = 6'b000101; rtc = 1; tick(); tick();
    check("R6", "no status in active", 32'(wake_stat), 32'd0);

    cur_tag = "R3";
    frc = 0; ss1 = 1; wait_req = 1; tick(); tick();
    check("R3", "err set no frc", 32'(werr), 32'd1);
    check("R3", "still active", 32'(mode), 32'd0);
    err_clr = 1; tick(); tick();
    check("R3", "err cleared", 32'(werr), 32'd0);
    frc = 1; ss1 = 0; wait_req = 1; err_clr = 1; tick(); tick();
    check("R3", "set wins over clear", 32'(werr), 32'd1);
    err_clr = 1; tick(); tick();

    cur_tag = "R2";
    ss1 = 1; wait_req = 1; tick();
    check("R2", "entry clocks on", 32'(bus_en), 32'd1);
    ticks(ENT);
    check("R2", "wait clocks off", 32'(bus_en), 32'd0);
    check("R2", "wait stby", 32'(reg_stby), 32'd1);

    cur_tag = "R7";
    rtt = 1; tick(); force_w = 1; tick(); supply = 1; tick(); pins = 6'b000010; tick();
    check("R7", "ignored sources keep wait", 32'(mode), 32'd1);
    cur_tag = "R12";
    regoff_req = 1; tick(); wfe_req = 1; deep = 1; tick(); wait_req = 1; tick(); deep = 0;
    check("R12", "requests ignored in wait", 32'(reg_stby), 32'd1);
    cur_tag = "R7";
    pins = 6'b000100; tick(); tick();
    check("R7", "stby dropped", 32'(reg_stby), 32'd0);
    check("R7", "clk still gated", 32'(bus_en), 32'd0);
    ticks(WK - 1);
    check("R7", "back active", 32'(bus_en), 32'd1);

    cur_tag = "R11";
    check("R11", "stat pin2", 32'(wake_stat), 32'h004);
    stat_clr = 11'h004; tick(); tick();
    check("R11", "stat cleared", 32'(wake_stat), 32'h000);

    cur_tag = "R10";
    wait_req = 1; tick();
    pins = 6'b000001; stat_clr = 11'h001; tick(); tick();
    check("R10", "wait entry aborted", 32'(mode), 32'd0);
    check("R11", "set wins on abort", 32'(wake_stat), 32'h001);
    regoff_req = 1; tick();
    rtc = 1; tick(); tick();
    check("R10", "backup entry aborted", 32'(reg_on), 32'd1);
    check("R11", "rtc recorded", 32'(wake_stat), 32'h201);

    cur_tag = "R4";
    wfe_req = 1; tick(); tick();
    check("R4", "wfe without deep ignored", 32'(reg_on), 32'd1);
    frc = 0; wait_req = 1; tick(); frc = 1;  // err set for R9
    deep = 1; wfe_req = 1; tick();
    ticks(ENT);
    check("R4", "reg off", 32'(reg_on), 32'd0);
    check("R4", "shdn high", 32'(shdn), 32'd1);
    cur_tag = "R5";
    ticks(ROFF);
    check("R5", "shdn low", 32'(shdn), 32'd0);
    cur_tag = "R8";
    supply = 1; tick(); tick();
    check("R8", "disabled supply ignored", 32'(shdn), 32'd0);
    force_w = 1; tick(); tick();
    check("R8", "reset phase", 32'(srst_n), 32'd0);
    check("R8", "reg back on", 32'(reg_on), 32'd1);
    cur_tag = "R9";
    ticks(RST);
    check("R9", "err cleared by backup exit", 32'(werr), 32'd0);
    check("R9", "wake_en kept", 32'(wake_en), 32'(EN_VAL));
    check("R9", "stat kept", 32'(wake_stat), 32'h241);

    cur_tag = "R4";
    deep = 0; regoff_req = 1; wait_req = 1; tick();
    ticks(ENT);
    check("R4", "backup wins priority", 32'(mode), 32'd2);
    ticks(ROFF + 2);
    cur_tag = "R8";
    tamper = 1; tick();
    ticks(RST + 1);
    check("R8", "tamper recorded", 32'(wake_stat), 32'h341);

    cur_tag = "R5";
    supply = 1; tick(); en_we = 1; en_wdata = 11'h7ff; tick(); supply = 1; tick(); tick();
    check("R5", "supply event keeps shdn", 32'(shdn), 32'd1);
    ticks(2);

    done_flag = 1;
    summary();
    $finish;
  end
endmodule